// File: doc/BRIEF.md
# Four-Stage 8-bit Load/Store Pipeline Core

This block is a small 8-bit processor core built as a four-stage in-order pipeline. The stages are fetch, decode, execute and memory/write-back. Its 24-bit instructions come from an internal 256-word program store. A plain write port fills that store while the core is still held in reset. The core keeps eight 8-bit general registers and a three-flag status word. It reaches data memory through a 10-bit address, an 8-bit write bus with a write strobe, and a separate 8-bit read bus.

Results move from the last stage straight back into execute, so back-to-back dependent instructions run without stalls. This also covers a load followed at once by a consumer. Branches and jumps resolve in execute. A taken one discards the two instructions fetched behind it and steers the next-PC selector to the target. The integrating system holds `rst_n` low, loads the program, and then releases reset, synchronised to `clk`.

Top module: `byte_pipe_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, the PC, all registers and the status word are zero, and `dmem_oe` is low. The program store accepts writes through `prog_we`/`prog_addr`/`prog_data` while reset is held.
- R2: Instruction layout: opcode in bits 23..16, register A in bits 15..13, register B in bits 12..10, and a 10-bit address field in bits 9..0.
- R3: Without a taken branch, the PC advances by one each cycle, so one instruction completes per cycle.
- R4: ADD (0x01), SUB (0x02), AND (0x03), OR (0x04) and MUL (0x05) take register A and register B as operands and write the 8-bit result to register A. MUL keeps only the low 8 bits of the product.
- R5: Load-immediate (0x0A) writes address bits 7..0 into register A. Bits 9..8 of the address field are ignored by load-immediate, branch-if-zero and jump.
- R6: LOAD (0x06) writes register A from data memory at the 10-bit address field. STORE (0x07) drives register A on `dmem_wdata` at that address. `dmem_oe` is high exactly for the one cycle a STORE spends in the last stage.
- R7: `status_o` is {N, C, Z} (bit 2 negative, bit 1 carry, bit 0 zero). Only the five ALU opcodes change it. C is the carry-out for ADD, the inverted borrow for SUB, 0 for AND and OR, and 1 for MUL when the discarded upper product byte is non-zero.
- R8: Jump (0x09) always branches. Branch-if-zero (0x08) branches when Z is set. The target is address bits 7..0, and the two instructions behind a taken branch have no effect.
- R9: An instruction that reads a register written by the instruction one or two places ahead of it sees the new value. This includes a value just returned by LOAD.
- R10: Opcode 0x00 and every unassigned opcode change no register, no flag and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 24 | Instruction word to store |
| dmem_addr | output | 10 | Data memory address |
| dmem_wdata | output | 8 | Data to write |
| dmem_oe | output | 1 | Write strobe / output enable, high for a STORE in the last stage |
| dmem_rdata | input | 8 | Data read back from memory at `dmem_addr` |
| status_o | output | 3 | Status word {N, C, Z} |

## Verification
The hardest cases to reach from the ports are a taken branch whose two shadow instructions would visibly change state, and a LOAD whose result is consumed in the very next cycle. Directed programs place a register-writing load-immediate in each branch shadow and then store that register, so a missing flush shows up in memory. Another program follows a LOAD with an ADD of the loaded register to itself, which exercises the path from the read bus into execute. Register values are exposed only through STORE instructions into the bench's memory model.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int OPC_W = 8;
  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_NOP   = 8'h00;
  localparam opc_t OPC_ADD   = 8'h01;
  localparam opc_t OPC_SUB   = 8'h02;
  localparam opc_t OPC_AND   = 8'h03;
  localparam opc_t OPC_OR    = 8'h04;
  localparam opc_t OPC_MUL   = 8'h05;
  localparam opc_t OPC_LOAD  = 8'h06;
  localparam opc_t OPC_STORE = 8'h07;
  localparam opc_t OPC_BZ    = 8'h08;
  localparam opc_t OPC_JMP   = 8'h09;
  localparam opc_t OPC_LDI   = 8'h0A;

  // status word, bit 2 negative, bit 1 carry, bit 0 zero
  typedef struct packed {
    logic neg;
    logic cry;
    logic zero;
  } psw_t;

  function automatic logic op_is_alu(opc_t op);
    return (op >= OPC_ADD) && (op <= OPC_MUL);
  endfunction

  function automatic logic op_writes_reg(opc_t op);
    return op_is_alu(op) || (op == OPC_LOAD) || (op == OPC_LDI);
  endfunction
endpackage

// File: rtl/bpc_imem.sv
module bpc_imem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/bpc_regfile.sv
module bpc_regfile #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int NREG = 1 << SEL_W;

  logic [DATA_W-1:0] gpr_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gpr_q[i] <= '0;
    end else if (wr_en) begin
      gpr_q[wr_sel] <= wr_data;
    end
  end

  // write-through so decode sees the value retiring this cycle
  assign rd_data_a = (wr_en && (wr_sel == rd_sel_a)) ? wr_data : gpr_q[rd_sel_a];
  assign rd_data_b = (wr_en && (wr_sel == rd_sel_b)) ? wr_data : gpr_q[rd_sel_b];
endmodule

// File: rtl/bpc_alu.sv
module bpc_alu
  import bpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opc_t              op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output psw_t              flags,
  output logic              flags_upd
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   sum;
  logic [DATA_W:0]   diff;
  logic [PROD_W-1:0] prod;
  logic              carry;

  always_comb begin
    sum       = {1'b0, opnd_a} + {1'b0, opnd_b};
    diff      = {1'b0, opnd_a} - {1'b0, opnd_b};
    prod      = PROD_W'(opnd_a) * PROD_W'(opnd_b);
    result    = '0;
    carry     = 1'b0;
    flags_upd = 1'b1;
    case (op)
      OPC_ADD: begin result = sum[DATA_W-1:0];  carry = sum[DATA_W];   end
      OPC_SUB: begin result = diff[DATA_W-1:0]; carry = ~diff[DATA_W]; end
      OPC_AND: result = opnd_a & opnd_b;
      OPC_OR:  result = opnd_a | opnd_b;
      OPC_MUL: begin
        result = prod[DATA_W-1:0];
        carry  = |prod[PROD_W-1:DATA_W];
      end
      default: flags_upd = 1'b0;
    endcase
    flags.zero = (result == '0);
    flags.neg  = result[DATA_W-1];
    flags.cry  = carry;
  end
endmodule

// File: rtl/byte_pipe_core.sv
module byte_pipe_core
  import bpc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DADDR_W = 10,
  parameter int PC_W    = 8,
  parameter int REG_AW  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_we,
  input  logic [PC_W-1:0]      prog_addr,
  input  logic [OPC_W+2*REG_AW+DADDR_W-1:0] prog_data,
  output logic [DADDR_W-1:0]   dmem_addr,
  output logic [DATA_W-1:0]    dmem_wdata,
  output logic                 dmem_oe,
  input  logic [DATA_W-1:0]    dmem_rdata,
  output logic [2:0]           status_o
);
  localparam int INSTR_W = OPC_W + 2*REG_AW + DADDR_W;
  localparam int OP_LSB  = INSTR_W - OPC_W;
  localparam int RA_LSB  = DADDR_W + REG_AW;
  localparam int RB_LSB  = DADDR_W;

  // fetch
  logic [PC_W-1:0]    pc_q, pc_d;
  logic [INSTR_W-1:0] fetch_word;
  // fetch -> decode
  logic               ifid_valid_q, ifid_valid_d;
  logic [INSTR_W-1:0] ifid_instr_q;
  // decode
  opc_t               dec_op;
  logic [REG_AW-1:0]  dec_ra, dec_rb;
  logic [DATA_W-1:0]  dec_va, dec_vb;
  // decode -> execute
  logic               idex_valid_q, idex_valid_d;
  opc_t               idex_op_q;
  logic [REG_AW-1:0]  idex_ra_q, idex_rb_q;
  logic [DADDR_W-1:0] idex_addr_q;
  logic [DATA_W-1:0]  idex_va_q, idex_vb_q;
  // execute
  logic [DATA_W-1:0]  ex_a, ex_b, alu_res, ex_res;
  psw_t               alu_flags, psw_q, psw_d;
  logic               alu_upd, ex_taken;
  logic [PC_W-1:0]    ex_target;
  // execute -> memory/write-back
  logic               exwb_valid_q;
  opc_t               exwb_op_q;
  logic [REG_AW-1:0]  exwb_ra_q;
  logic [DADDR_W-1:0] exwb_addr_q;
  logic [DATA_W-1:0]  exwb_res_q;
  logic               wb_wr;
  logic [DATA_W-1:0]  wb_val;

  bpc_imem #(.ADDR_W(PC_W), .WORD_W(INSTR_W)) imem_i (
    .clk(clk), .wr_en(prog_we), .wr_addr(prog_addr), .wr_data(prog_data),
    .rd_addr(pc_q), .rd_data(fetch_word)
  );

  assign dec_op = ifid_instr_q[OP_LSB +: OPC_W];
  assign dec_ra = ifid_instr_q[RA_LSB +: REG_AW];
  assign dec_rb = ifid_instr_q[RB_LSB +: REG_AW];

  bpc_regfile #(.DATA_W(DATA_W), .SEL_W(REG_AW)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wb_wr), .wr_sel(exwb_ra_q), .wr_data(wb_val),
    .rd_sel_a(dec_ra), .rd_sel_b(dec_rb),
    .rd_data_a(dec_va), .rd_data_b(dec_vb)
  );

  // last stage result and forwarding into execute
  assign wb_wr  = exwb_valid_q && op_writes_reg(exwb_op_q);
  assign wb_val = (exwb_op_q == OPC_LOAD) ? dmem_rdata : exwb_res_q;
  assign ex_a   = (wb_wr && (exwb_ra_q == idex_ra_q)) ? wb_val : idex_va_q;
  assign ex_b   = (wb_wr && (exwb_ra_q == idex_rb_q)) ? wb_val : idex_vb_q;

  bpc_alu #(.DATA_W(DATA_W)) alu_i (
    .op(idex_op_q), .opnd_a(ex_a), .opnd_b(ex_b),
    .result(alu_res), .flags(alu_flags), .flags_upd(alu_upd)
  );

  // next-state logic
  always_comb begin
    ex_target = idex_addr_q[PC_W-1:0];
    ex_taken  = idex_valid_q &&
                ((idex_op_q == OPC_JMP) || ((idex_op_q == OPC_BZ) && psw_q.zero));
    case (idex_op_q)
      OPC_LDI:   ex_res = idex_addr_q[DATA_W-1:0];
      OPC_STORE: ex_res = ex_a;
      default:   ex_res = alu_res;
    endcase
    psw_d        = (idex_valid_q && alu_upd) ? alu_flags : psw_q;
    pc_d         = ex_taken ? ex_target : pc_q + PC_W'(1);
    ifid_valid_d = !ex_taken;
    idex_valid_d = ifid_valid_q && !ex_taken;
  end

  // control state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= '0;
      psw_q        <= '0;
      ifid_valid_q <= 1'b0;
      idex_valid_q <= 1'b0;
      exwb_valid_q <= 1'b0;
    end else begin
      pc_q         <= pc_d;
      psw_q        <= psw_d;
      ifid_valid_q <= ifid_valid_d;
      idex_valid_q <= idex_valid_d;
      exwb_valid_q <= idex_valid_q;
    end
  end

  // datapath registers, loaded only behind a valid slot
  always_ff @(posedge clk) begin
    ifid_instr_q <= fetch_word;
    if (ifid_valid_q) begin
      idex_op_q   <= dec_op;
      idex_ra_q   <= dec_ra;
      idex_rb_q   <= dec_rb;
      idex_addr_q <= ifid_instr_q[DADDR_W-1:0];
      idex_va_q   <= dec_va;
      idex_vb_q   <= dec_vb;
    end
    if (idex_valid_q) begin
      exwb_op_q   <= idex_op_q;
      exwb_ra_q   <= idex_ra_q;
      exwb_addr_q <= idex_addr_q;
      exwb_res_q  <= ex_res;
    end
  end

  assign dmem_addr  = exwb_addr_q;
  assign dmem_wdata = exwb_res_q;
  assign dmem_oe    = exwb_valid_q && (exwb_op_q == OPC_STORE);
  assign status_o   = psw_q;
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc_q,
  input logic [2:0]      psw_q,
  input logic            taken,
  input logic [PC_W-1:0] target,
  input logic            ifid_valid,
  input logic            idex_valid,
  input opc_t            idex_op,
  input logic            dmem_oe
);
  logic ex_store, ex_alu;
  assign ex_store = idex_valid && (idex_op == OPC_STORE);
  assign ex_alu   = idex_valid && op_is_alu(idex_op);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_q == '0 && psw_q == '0 && !dmem_oe)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> (pc_q == PC_W'($past(pc_q) + 1'b1))); // R3
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (pc_q == $past(target))); // R8
  AST_SHADOW_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (!ifid_valid && !idex_valid)); // R8
  AST_STORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_store |=> dmem_oe); // R6
  AST_STROBE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_oe |-> $past(ex_store)); // R6
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_alu |=> $stable(psw_q)); // R7
endmodule

bind byte_pipe_core bpc_checker #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_q(pc_q), .psw_q(psw_q),
  .taken(ex_taken), .target(ex_target),
  .ifid_valid(ifid_valid_q), .idex_valid(idex_valid_q),
  .idex_op(idex_op_q), .dmem_oe(dmem_oe)
);

// File: tb/byte_pipe_core_tb.sv
module byte_pipe_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [7:0]  prog_addr;
  logic [23:0] prog_data;
  logic [9:0]  dmem_addr;
  logic [7:0]  dmem_wdata;
  logic        dmem_oe;
  logic [7:0]  dmem_rdata;
  logic [2:0]  status_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  mem [1024];
  int          oe_cnt;
  logic        clr_req;
  logic        pre_we;
  logic [9:0]  pre_addr;
  logic [7:0]  pre_data;
  logic [23:0] prog [64];
  int          plen;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_pipe_core dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_oe(dmem_oe), .dmem_rdata(dmem_rdata), .status_o(status_o)
  );

  // data memory model
  assign dmem_rdata = mem[dmem_addr];
  always @(posedge clk) begin
    if (clr_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'hEE;
      oe_cnt <= 0;
    end else begin
      if (pre_we) mem[pre_addr] <= pre_data;
      if (dmem_oe) begin
        mem[dmem_addr] <= dmem_wdata;
        oe_cnt <= oe_cnt + 1;
      end
    end
  end

  function automatic logic [23:0] ins(logic [7:0] op, logic [2:0] ra, logic [2:0] rb,
                                      logic [9:0] ad);
    return {op, ra, rb, ad};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // hold reset, clear memory, write the program store
  task automatic load_prog();
    @(negedge clk);
    rst_n   = 1'b0;
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    for (int i = 0; i < plen; i++) begin
      prog_we = 1'b1; prog_addr = 8'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
  endtask

  task automatic poke(logic [9:0] a, logic [7:0] d);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic release_run(int ncyc);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic t_reset();
    plen = 3;
    prog[0] = ins(8'h07, 3'd3, 3'd0, 10'h200);
    prog[1] = ins(8'h07, 3'd7, 3'd0, 10'h201);
    prog[2] = ins(8'h09, 3'd0, 3'd0, 10'h002);
    load_prog();
    chk("R1 status in reset", status_o, 0);
    chk("R1 oe in reset", dmem_oe, 0);
    release_run(20);
    chk("R1 r3 after reset", mem[10'h200], 8'h00);
    chk("R1 r7 after reset", mem[10'h201], 8'h00);
    chk("R6 store count", oe_cnt, 2);
  endtask

  task automatic t_alu();
    plen = 17;
    prog[0]  = ins(8'h0A, 3'd1, 3'd0, 10'h005);
    prog[1]  = ins(8'h0A, 3'd2, 3'd0, 10'h003);
    prog[2]  = ins(8'h01, 3'd1, 3'd2, 10'h000);
    prog[3]  = ins(8'h07, 3'd1, 3'd0, 10'h010);
    prog[4]  = ins(8'h02, 3'd2, 3'd1, 10'h000);
    prog[5]  = ins(8'h07, 3'd2, 3'd0, 10'h011);
    prog[6]  = ins(8'h0A, 3'd5, 3'd0, 10'h0F0);
    prog[7]  = ins(8'h0A, 3'd6, 3'd0, 10'h03C);
    prog[8]  = ins(8'h03, 3'd5, 3'd6, 10'h000);
    prog[9]  = ins(8'h04, 3'd6, 3'd5, 10'h000);
    prog[10] = ins(8'h07, 3'd5, 3'd0, 10'h012);
    prog[11] = ins(8'h07, 3'd6, 3'd0, 10'h013);
    prog[12] = ins(8'h0A, 3'd3, 3'd0, 10'h320);
    prog[13] = ins(8'h0A, 3'd4, 3'd0, 10'h010);
    prog[14] = ins(8'h05, 3'd3, 3'd4, 10'h000);
    prog[15] = ins(8'h07, 3'd3, 3'd0, 10'h3FF);
    prog[16] = ins(8'h09, 3'd0, 3'd0, 10'h010);
    load_prog();
    release_run(40);
    chk("R4 R9 add with forwarding", mem[10'h010], 8'h08);
    chk("R4 sub wraps", mem[10'h011], 8'hFB);
    chk("R4 and", mem[10'h012], 8'h30);
    chk("R4 or", mem[10'h013], 8'h3C);
    chk("R4 mul truncated, R5 imm bits 9..8 ignored", mem[10'h3FF], 8'h00);
    chk("R7 mul flags Z C held past store/ldi/jmp", status_o, 3'b011);
    chk("R6 store count", oe_cnt, 5);
    chk("R2 untouched neighbour", mem[10'h014], 8'hEE);
  endtask

  task automatic t_carry();
    plen = 5;
    prog[0] = ins(8'h0A, 3'd1, 3'd0, 10'h0FF);
    prog[1] = ins(8'h0A, 3'd2, 3'd0, 10'h001);
    prog[2] = ins(8'h01, 3'd1, 3'd2, 10'h000);
    prog[3] = ins(8'h07, 3'd1, 3'd0, 10'h3FE);
    prog[4] = ins(8'h09, 3'd0, 3'd0, 10'h004);
    load_prog();
    release_run(25);
    chk("R4 add wraps", mem[10'h3FE], 8'h00);
    chk("R7 add carry and zero", status_o, 3'b011);
  endtask

  task automatic t_load();
    plen = 4;
    prog[0] = ins(8'h06, 3'd1, 3'd0, 10'h155);
    prog[1] = ins(8'h01, 3'd1, 3'd1, 10'h000);
    prog[2] = ins(8'h07, 3'd1, 3'd0, 10'h156);
    prog[3] = ins(8'h09, 3'd0, 3'd0, 10'h003);
    load_prog();
    poke(10'h155, 8'h5A);
    release_run(25);
    chk("R9 R6 load forwarded to next add", mem[10'h156], 8'hB4);
    chk("R7 negative flag", status_o, 3'b100);
  endtask

  task automatic t_branch();
    plen = 14;
    prog[0]  = ins(8'h0A, 3'd1, 3'd0, 10'h001);
    prog[1]  = ins(8'h0A, 3'd2, 3'd0, 10'h001);
    prog[2]  = ins(8'h02, 3'd1, 3'd2, 10'h000);
    prog[3]  = ins(8'h08, 3'd0, 3'd0, 10'h006);
    prog[4]  = ins(8'h0A, 3'd3, 3'd0, 10'h0AA);
    prog[5]  = ins(8'h0A, 3'd3, 3'd0, 10'h0BB);
    prog[6]  = ins(8'h07, 3'd3, 3'd0, 10'h020);
    prog[7]  = ins(8'h0A, 3'd4, 3'd0, 10'h011);
    prog[8]  = ins(8'h01, 3'd4, 3'd4, 10'h000);
    prog[9]  = ins(8'h08, 3'd0, 3'd0, 10'h00C);
    prog[10] = ins(8'h07, 3'd4, 3'd0, 10'h021);
    prog[11] = ins(8'h09, 3'd0, 3'd0, 10'h30D);
    prog[12] = ins(8'h07, 3'd4, 3'd0, 10'h022);
    prog[13] = ins(8'h09, 3'd0, 3'd0, 10'h00D);
    load_prog();
    release_run(40);
    chk("R8 taken branch flushes shadow", mem[10'h020], 8'h00);
    chk("R8 untaken branch falls through", mem[10'h021], 8'h22);
    chk("R8 R5 jump skips, target bits 9..8 ignored", mem[10'h022], 8'hEE);
    chk("R3 store count", oe_cnt, 2);
    chk("R7 flags after add", status_o, 3'b000);
  endtask

  task automatic t_unknown();
    plen = 5;
    prog[0] = ins(8'h0A, 3'd1, 3'd0, 10'h077);
    prog[1] = ins(8'hC3, 3'd1, 3'd1, 10'h031);
    prog[2] = ins(8'h00, 3'd1, 3'd1, 10'h031);
    prog[3] = ins(8'h07, 3'd1, 3'd0, 10'h030);
    prog[4] = ins(8'h09, 3'd0, 3'd0, 10'h004);
    load_prog();
    release_run(25);
    chk("R10 register kept", mem[10'h030], 8'h77);
    chk("R10 no memory write", mem[10'h031], 8'hEE);
    chk("R10 flags kept", status_o, 3'b000);
    chk("R10 store count", oe_cnt, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    clr_req = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    t_reset();
    t_alu();
    t_carry();
    t_load();
    t_branch();
    t_unknown();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule